// File: doc/BRIEF.md
# Embedded Sync Code Channel Demultiplexer

This block sits behind the deserialiser of a camera serial link and accepts the incoming byte stream one byte per valid strobe. It searches the stream for four-byte embedded synchronisation codes: three fixed prefix bytes, 0xFF then 0x00 then 0x00, and a fourth byte that names a logical channel and an event. Each recognised code is decoded into one of four events (line start, line end, frame start, frame end) for one of up to eight logical channels. The block keeps line and frame state for every channel and tracks which channel the stream currently belongs to.

Payload bytes between codes are steered to the per-channel valid strobe of the active channel, so that video streams interleaved on one link are separated. Code bytes never reach the data output. Every byte passes through a three-byte match window. A prefix that turns out not to be a code is released as ordinary payload, in arrival order. Single-cycle pulses report each decoded event, each malformed code, each frame protocol violation and each payload byte discarded outside a line. Link bytes are sent least significant bit first; that ordering is resolved upstream, and this block works on whole bytes.

Top module: `sync_demux`

## Requirements
- R1: Four accepted bytes 0xFF, 0x00, 0x00, X in a row form a sync code. None of the four ever appears on the data output, and the cycle that reports the code carries no data or drop pulse.
- R2: In X, bits [7:4] give the channel and bits [3:0] give the event: 0 line start, 1 line end, 2 frame start, 3 frame end. One clock after X is accepted, `evtValid` pulses for one cycle with `evtType` set to bits [1:0] and `evtChan` set to the channel.
- R3: If bits [7:4] of X are 8 or more, or bits [3:0] are 4 or more, then `invalidCode` pulses one clock later instead of `evtValid`. The code bytes are still consumed, and no channel state or active channel changes.
- R4: A payload byte is delivered on `outData`. It pulses exactly one bit of `chanValid`, the bit of the channel named by the most recent valid code (channel 0 after reset), and `outChan` holds that channel number.
- R5: A payload byte is forwarded only while the active channel is inside a line. A line is opened by a line start or frame start for that channel and closed by a line end or frame end. Any other payload byte raises `dropPulse` for one cycle in place of the data strobe.
- R6: A broken prefix (0xFF, or 0xFF 0x00, or 0xFF 0x00 0x00, followed by a byte that does not continue the code) is released as payload in its original order. A 0xFF inside the broken prefix, or the breaking byte itself, may start the next code.
- R7: A payload byte appears one clock after the third later byte is accepted. Cycles with `inValid` low move nothing and produce no pulse of any kind.
- R8: Each channel has a frame flag, set by frame start and cleared by frame end. A frame start while the flag is set, or a frame end while it is clear, pulses `protoErr` with `protoChan` set to the channel, together with the event pulse. The event still takes effect.
- R9: After reset all pulses are low, every channel is outside line and frame, the active channel is 0 and the match window is empty.
- R10: Line and frame state are kept per channel. A code for one channel leaves the state of every other channel untouched, so switching back to a channel finds its line state as it was left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Deserialised link byte |
| inValid | input | 1 | inByte holds a new byte this cycle |
| chanValid | output | NUM_CHAN | One-hot per-channel payload strobe |
| outData | output | 8 | Payload byte |
| outChan | output | 3 | Channel of the payload byte |
| dropPulse | output | 1 | Payload byte discarded outside a line |
| evtValid | output | 1 | Valid sync code decoded |
| evtType | output | 2 | Event: 0 line start, 1 line end, 2 frame start, 3 frame end |
| evtChan | output | 3 | Channel of the event |
| invalidCode | output | 1 | Malformed fourth code byte seen |
| protoErr | output | 1 | Frame start in frame or frame end out of frame |
| protoChan | output | 3 | Channel of the protocol error |

## Verification
The bench targets overlapping prefixes such as 0xFF 0xFF 0x00 0x00 X and broken ones such as 0xFF 0x00 0x07. A design that resets its matcher wrongly would swallow a real code or drop or reorder the held bytes. Malformed fourth bytes are followed by payload whose routing exposes any state change a faulty decoder would make. Repeated frame starts and frame ends, interleaved channels and idle gaps between bytes check the protocol flag, per-channel line state and the three-byte latency. A wrong latency or a stall that still shifts the window would misplace every output byte.

// File: rtl/sync_demux_pkg.sv
package sync_demux_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAN_W = 3;
  localparam int WIN_BYTES = 3;
  localparam logic [WIN_BYTES*BYTE_W-1:0] SYNC_PREFIX = 24'hFF_00_00;

  typedef enum logic [1:0] {
    EV_LINE_START  = 2'd0,
    EV_LINE_END    = 2'd1,
    EV_FRAME_START = 2'd2,
    EV_FRAME_END   = 2'd3
  } evKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              fwd;   // active channel is inside a line
    logic [CHAN_W-1:0] chan;  // active channel
  } ctrlStrobe_t;
endpackage

// File: rtl/sync_demux_dp.sv
module sync_demux_dp
  import sync_demux_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BYTE_W-1:0]   inByte,
  input  logic                inValid,
  input  ctrlStrobe_t         ctl,
  output logic                hit,
  output logic [NUM_CHAN-1:0] chanValid,
  output logic [BYTE_W-1:0]   outData,
  output logic [CHAN_W-1:0]   outChan,
  output logic                dropPulse
);
  localparam int WIN_W = WIN_BYTES * BYTE_W;

  logic [WIN_W-1:0]     winBytes;  // newest byte in the low lane
  logic [WIN_BYTES-1:0] winVld;
  logic                 emit;
  logic [BYTE_W-1:0]    oldest;
  logic [NUM_CHAN-1:0]  chanHot;

  // R1: full window equal to the prefix plus any fourth byte is a code
  assign hit    = inValid && (&winVld) && (winBytes == SYNC_PREFIX);
  // R6/R7: the oldest held byte leaves as payload when a byte is pushed in
  assign emit   = inValid && !hit && winVld[WIN_BYTES-1];
  assign oldest = winBytes[WIN_W-1 -: BYTE_W];
  assign chanHot = NUM_CHAN'(1) << ctl.chan;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winBytes <= '0;
      winVld   <= '0;
    end else if (hit) begin
      winVld <= '0;
    end else if (inValid) begin
      winBytes <= {winBytes[WIN_W-BYTE_W-1:0], inByte};
      winVld   <= {winVld[WIN_BYTES-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanValid <= '0;
      outData   <= '0;
      outChan   <= '0;
      dropPulse <= 1'b0;
    end else begin
      chanValid <= (emit && ctl.fwd) ? chanHot : '0;
      dropPulse <= emit && !ctl.fwd;
      if (emit) begin
        outData <= oldest;
        outChan <= ctl.chan;
      end
    end
  end
endmodule

// File: rtl/sync_demux_ctl.sv
module sync_demux_ctl
  import sync_demux_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hit,
  input  logic [BYTE_W-1:0] codeByte,
  output ctrlStrobe_t       ctl,
  output logic              evtValid,
  output logic [1:0]        evtType,
  output logic [CHAN_W-1:0] evtChan,
  output logic              invalidCode,
  output logic              protoErr,
  output logic [CHAN_W-1:0] protoChan
);
  localparam logic [3:0] CHAN_LIMIT = 4'(NUM_CHAN);

  logic [NUM_CHAN-1:0] inLine, inFrame, nextLine, nextFrame;
  logic [CHAN_W-1:0]   activeChan;
  logic [CHAN_W-1:0]   codeChan;
  evKind_t             kind;
  logic                codeOk, apply, seqErr;

  // R2/R3: decode the fourth byte
  assign codeChan = codeByte[CHAN_W+3:4];
  assign kind     = evKind_t'(codeByte[1:0]);
  assign codeOk   = (codeByte[7:4] < CHAN_LIMIT) && (codeByte[3:2] == 2'b00);
  assign apply    = hit && codeOk;
  // R8: frame sequence check against the addressed channel
  assign seqErr   = (kind == EV_FRAME_START &&  inFrame[codeChan]) ||
                    (kind == EV_FRAME_END   && !inFrame[codeChan]);

  // R10: each channel updates only on a code addressed to it
  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
    logic sel;
    assign sel = apply && (codeChan == CHAN_W'(i));
    // even kinds open, odd kinds close (R5)
    assign nextLine[i]  = sel ? ~codeByte[0] : inLine[i];
    assign nextFrame[i] = (sel && codeByte[1]) ? ~codeByte[0] : inFrame[i];
  end

  assign ctl.fwd  = inLine[activeChan];
  assign ctl.chan = activeChan;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inLine      <= '0;
      inFrame     <= '0;
      activeChan  <= '0;
      evtValid    <= 1'b0;
      evtType     <= '0;
      evtChan     <= '0;
      invalidCode <= 1'b0;
      protoErr    <= 1'b0;
      protoChan   <= '0;
    end else begin
      inLine      <= nextLine;
      inFrame     <= nextFrame;
      if (apply) activeChan <= codeChan;
      evtValid    <= apply;
      invalidCode <= hit && !codeOk;
      protoErr    <= apply && seqErr;
      if (apply) begin
        evtType   <= kind;
        evtChan   <= codeChan;
        protoChan <= codeChan;
      end
    end
  end
endmodule

// File: rtl/sync_demux.sv
module sync_demux
  import sync_demux_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          inByte,
  input  logic                inValid,
  output logic [NUM_CHAN-1:0] chanValid,
  output logic [7:0]          outData,
  output logic [2:0]          outChan,
  output logic                dropPulse,
  output logic                evtValid,
  output logic [1:0]          evtType,
  output logic [2:0]          evtChan,
  output logic                invalidCode,
  output logic                protoErr,
  output logic [2:0]          protoChan
);
  ctrlStrobe_t ctl;
  logic        hit;

  sync_demux_dp #(.NUM_CHAN(NUM_CHAN)) u_dp (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .ctl(ctl), .hit(hit), .chanValid(chanValid), .outData(outData),
    .outChan(outChan), .dropPulse(dropPulse)
  );

  sync_demux_ctl #(.NUM_CHAN(NUM_CHAN)) u_ctl (
    .clk(clk), .rstN(rstN), .hit(hit), .codeByte(inByte), .ctl(ctl),
    .evtValid(evtValid), .evtType(evtType), .evtChan(evtChan),
    .invalidCode(invalidCode), .protoErr(protoErr), .protoChan(protoChan)
  );
endmodule

// File: rtl/sync_demux_chk.sv
module sync_demux_chk #(
  parameter int NUM_CHAN = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [NUM_CHAN-1:0] chanValid,
  input logic [2:0]          outChan,
  input logic                dropPulse,
  input logic                evtValid,
  input logic [1:0]          evtType,
  input logic [2:0]          evtChan,
  input logic                invalidCode,
  input logic                protoErr,
  input logic [2:0]          protoChan
);
  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanValid));

  assert_chan_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|chanValid) |-> chanValid[outChan]);

  assert_code_no_data_R1: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (chanValid == '0 && !dropPulse));

  assert_invalid_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    invalidCode |-> (!evtValid && chanValid == '0 && !dropPulse && !protoErr));

  assert_err_with_event_R8: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> (evtValid && protoChan == evtChan && evtType[1]));

  assert_drop_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    dropPulse |-> (chanValid == '0));

  assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (chanValid == '0 && !dropPulse && !evtValid && !invalidCode));
endmodule

bind sync_demux sync_demux_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (.*);

// File: tb/sync_demux_bench.sv
module sync_demux_bench;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [7:0]     inByte = '0;
  logic           inValid = 1'b0;
  logic [NCH-1:0] chanValid;
  logic [7:0]     outData;
  logic [2:0]     outChan;
  logic           dropPulse, evtValid, invalidCode, protoErr;
  logic [1:0]     evtType;
  logic [2:0]     evtChan, protoChan;

  always #4 clk = ~clk;

  sync_demux #(.NUM_CHAN(NCH)) u_sync_demux (.*);

  int nChecks = 0;
  int nFails  = 0;

  // reference state
  logic [7:0] pend[$];
  bit         mLine[NCH];
  bit         mFrame[NCH];
  int         mAct;

  logic [NCH-1:0] eVld;
  logic [7:0]     eData;
  logic [2:0]     eChan, eEvChan;
  logic [1:0]     eEvType;
  logic           eDrop, eEvt, eInv, eErr;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic v, input logic [7:0] b);
    eVld = '0; eDrop = 0; eEvt = 0; eInv = 0; eErr = 0;
    if (!v) return;
    if (pend.size() == 3 && pend[0] == 8'hFF && pend[1] == 8'h00 && pend[2] == 8'h00) begin
      pend.delete();
      if (b[7:4] < 4'd8 && b[3:0] < 4'd4) begin
        int ch = int'(b[6:4]);
        eEvt = 1; eEvType = b[1:0]; eEvChan = b[6:4];
        eErr = (b[1:0] == 2'd2 && mFrame[ch]) || (b[1:0] == 2'd3 && !mFrame[ch]);
        mLine[ch] = (b[0] == 1'b0);
        if (b[1]) mFrame[ch] = (b[0] == 1'b0);
        mAct = ch;
      end else begin
        eInv = 1;
      end
    end else begin
      if (pend.size() == 3) begin
        logic [7:0] o = pend.pop_front();
        if (mLine[mAct]) begin
          eVld = NCH'(1) << mAct; eData = o; eChan = 3'(mAct);
        end else begin
          eDrop = 1;
        end
      end
      pend.push_back(b);
    end
  endfunction

  task automatic step(input logic v, input logic [7:0] b, input string req);
    inValid = v; inByte = b;
    model(v, b);
    @(negedge clk);
    chk(chanValid == eVld, {req, "/R4"}, "chanValid", int'(chanValid), int'(eVld));
    if (eVld != '0) begin
      chk(outData == eData, {req, "/R4"}, "outData", int'(outData), int'(eData));
      chk(outChan == eChan, {req, "/R4"}, "outChan", int'(outChan), int'(eChan));
    end
    chk(dropPulse == eDrop, {req, "/R5"}, "dropPulse", int'(dropPulse), int'(eDrop));
    chk(evtValid == eEvt, {req, "/R2"}, "evtValid", int'(evtValid), int'(eEvt));
    if (eEvt) begin
      chk(evtType == eEvType, {req, "/R2"}, "evtType", int'(evtType), int'(eEvType));
      chk(evtChan == eEvChan, {req, "/R2"}, "evtChan", int'(evtChan), int'(eEvChan));
    end
    chk(invalidCode == eInv, {req, "/R3"}, "invalidCode", int'(invalidCode), int'(eInv));
    chk(protoErr == eErr, {req, "/R8"}, "protoErr", int'(protoErr), int'(eErr));
    if (eErr)
      chk(protoChan == eEvChan, {req, "/R8"}, "protoChan", int'(protoChan), int'(eEvChan));
  endtask

  task automatic code(input logic [7:0] x, input string req);
    step(1, 8'hFF, req); step(1, 8'h00, req); step(1, 8'h00, req); step(1, x, req);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd5417));
    mAct = 0;
    for (int i = 0; i < NCH; i++) begin mLine[i] = 0; mFrame[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: quiet reset state
    chk(chanValid == '0 && !dropPulse && !evtValid && !invalidCode && !protoErr,
        "R9", "reset outputs", int'({chanValid, dropPulse, evtValid, invalidCode, protoErr}), 0);
    // R9: payload before any code is dropped (channel 0 not in line)
    step(1, 8'h11, "R9"); step(1, 8'h22, "R9"); step(1, 8'h33, "R9"); step(1, 8'h44, "R9");
    // R1/R2: frame start channel 1, then payload with stalls (R7)
    code(8'h12, "R1");
    step(1, 8'hA1, "R7"); step(0, 8'h00, "R7"); step(1, 8'hA2, "R7");
    step(0, 8'hFF, "R7"); step(1, 8'hA3, "R7"); step(1, 8'hA4, "R7");
    // R6: broken prefixes and overlap
    step(1, 8'hFF, "R6"); step(1, 8'h00, "R6"); step(1, 8'h07, "R6");
    step(1, 8'hFF, "R6"); step(1, 8'hFF, "R6"); step(1, 8'h00, "R6");
    step(1, 8'h00, "R6"); step(1, 8'h10, "R6");
    step(1, 8'hFF, "R6"); step(1, 8'h00, "R6"); step(1, 8'h00, "R6"); step(1, 8'hFF, "R6");
    step(1, 8'hB1, "R6"); step(1, 8'hB2, "R6"); step(1, 8'hB3, "R6");
    // R3: malformed codes change nothing
    code(8'h91, "R3"); step(1, 8'hC1, "R3");
    code(8'h35, "R3"); step(1, 8'hC2, "R3"); step(1, 8'hC3, "R3");
    step(1, 8'hC4, "R3"); step(1, 8'hC5, "R3");
    // R8: frame sequence errors
    code(8'h13, "R8"); code(8'h13, "R8");
    code(8'h32, "R8"); code(8'h32, "R8");
    step(1, 8'hD1, "R8"); step(1, 8'hD2, "R8"); step(1, 8'hD3, "R8");
    // R5: line end closes forwarding
    code(8'h31, "R5"); step(1, 8'hE1, "R5"); step(1, 8'hE2, "R5");
    step(1, 8'hE3, "R5"); step(1, 8'hE4, "R5");
    // R10: interleaved channels keep separate line state
    code(8'h02, "R10"); step(1, 8'h51, "R10");
    code(8'h50, "R10"); step(1, 8'h52, "R10");
    code(8'h01, "R10"); step(1, 8'h53, "R10");
    code(8'h50, "R10"); step(1, 8'h54, "R10"); step(1, 8'h55, "R10");
    step(1, 8'h56, "R10"); step(1, 8'h57, "R10");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 10);
      if (r < 2) begin
        logic [7:0] x;
        if ($urandom % 8 != 0) x = {1'b0, 3'($urandom), 4'($urandom % 4)};
        else x = 8'($urandom);
        code(x, "R2");
      end else if (r == 2) step(0, 8'($urandom), "R7");
      else if (r == 3) step(1, 8'hFF, "R6");
      else if (r == 4) step(1, 8'h00, "R6");
      else if (r == 5) begin
        step(1, 8'hFF, "R6"); step(1, 8'h00, "R6"); step(1, 8'($urandom), "R6");
      end else step(1, 8'($urandom), "R4");
    end
    step(0, 8'h00, "R7");
    summary();
    $finish;
  end
endmodule